// File: doc/BRIEF.md
# Waveform Timer Channel

This block is a single timer channel that drives two waveform pins. A counter advances once per cycle of a counter-clock qualifier while the channel is enabled. The counter runs up with wrap-around, or up to a programmable period value and back to zero. It can also count up and then down, turning at the period value or at the all-ones value. Two further compare values and the period value each raise a match event while the counter holds that value and a counter tick occurs.

Each of the two pins has four action codes, one for its own compare match, one for the period match, one for the external event and one for the software trigger. The action codes can leave the pin, set it, clear it or invert it. A trigger from software, from an enabled external edge or from the period match in an automatic mode restarts the count. A period match can also freeze the counter until the next trigger, or switch the channel's clock off until software turns it back on. Sticky status flags, a maskable interrupt and the live counter value are provided for the surrounding logic.

Top module: `wgt_channel`

## Requirements
- R1: After reset the counter is 0, both wave pins are low, all status flags and mask bits are 0, and the channel clock is off, so the counter holds 0 until a start command.
- R2: A `cmd_start` pulse turns the channel clock on, and the counter advances from the cycle after the pulse. A `cmd_stop` pulse turns it off. When both pulse together, the clock ends up off.
- R3: In mode 0 (`wave_mode`=0, up with wrap) the counter goes from all-ones to 0 and sets the overflow flag, `stat_flags` bit 0.
- R4: In mode 1 (up with automatic restart) the counter goes from the period value `top_val` to 0 on the next tick.
- R5: In mode 3 the counter turns to counting down at `top_val`, and in mode 2 it turns down at all-ones. In both modes it turns back up at 0 and never sets the overflow flag.
- R6: A software trigger (`cmd_kick`), or an external edge when `ext_trig_en` is 1, sets the counter to 0 on the next counter tick. A trigger seen while no tick occurs is held until a tick arrives. `ext_edge` selects the edge: 0 none, 1 rising, 2 falling, 3 both.
- R7: With `stop_on_top`, a period match freezes the counter until the next trigger. With `halt_on_top`, a period match turns the channel clock off, and only `cmd_start` resumes counting.
- R8: Action codes are 0 none, 1 set, 2 clear and 3 toggle. `wave_a` uses `cmp_a_val` as its compare source and `wave_b` uses `cmp_b_val`. A source whose code is 0 leaves the pin unchanged.
- R9: When several sources hit one pin in the same cycle, the pin follows the software trigger first, then the external event, then the period match, then the pin's own compare. Sources whose code is 0 are skipped.
- R10: `stat_flags` holds overflow (bit 0), compare A match (bit 1), compare B match (bit 2) and period match (bit 3). The flags are sticky. A `stat_rd` pulse clears them, but an event in the same cycle as the pulse still leaves its flag set.
- R11: `irq_set` sets bits of `irq_mask` and `irq_clr` clears them, with clear winning when both hit one bit. `irq` is high when any flag is set whose mask bit is also set.
- R12: While `cnt_tick` is low, the counter does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | Counter clock qualifier |
| cmd_start | input | 1 | Pulse: channel clock on |
| cmd_stop | input | 1 | Pulse: channel clock off |
| cmd_kick | input | 1 | Pulse: software trigger |
| wave_mode | input | 2 | 0 up, 1 up+auto restart, 2 up/down, 3 up/down at period |
| stop_on_top | input | 1 | Period match freezes counter |
| halt_on_top | input | 1 | Period match turns clock off |
| ext_in | input | 1 | External event input (synchronous) |
| ext_edge | input | 2 | External edge select |
| ext_trig_en | input | 1 | External edge acts as trigger |
| cmp_a_val | input | CNT_W | Compare value for wave_a |
| cmp_b_val | input | CNT_W | Compare value for wave_b |
| top_val | input | CNT_W | Period value |
| act_a_cmp | input | 2 | wave_a action on compare A |
| act_a_top | input | 2 | wave_a action on period match |
| act_a_ext | input | 2 | wave_a action on external event |
| act_a_sw | input | 2 | wave_a action on software trigger |
| act_b_cmp | input | 2 | wave_b action on compare B |
| act_b_top | input | 2 | wave_b action on period match |
| act_b_ext | input | 2 | wave_b action on external event |
| act_b_sw | input | 2 | wave_b action on software trigger |
| stat_rd | input | 1 | Status read, clears flags |
| irq_set | input | 4 | Mask bits to set |
| irq_clr | input | 4 | Mask bits to clear |
| cnt_value | output | CNT_W | Counter value |
| wave_a | output | 1 | Waveform pin A |
| wave_b | output | 1 | Waveform pin B |
| stat_flags | output | 4 | Sticky status flags |
| irq_mask | output | 4 | Interrupt mask |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the turning points of the counter. These are the all-ones wrap with its overflow flag and the period restart. In the up/down modes it covers both turnarounds, where an off-by-one design would overshoot to the period value plus one or underflow to all-ones. A trigger issued while ticks are paused must survive until the next tick, or the restart is silently lost. A frozen channel must restart from a trigger, while a clock-disabled channel must wait for a start command; confusing the two shows up as a counter that moves when it should hold. Simultaneous stimuli are also exercised: a trigger clashing with a period match on one pin, a status read coinciding with a new match, and mask set and clear on one bit. A design with the wrong priority would drive the pin to the opposite level or lose a flag.

// File: rtl/wgt_pkg.sv
package wgt_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TGL  = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    WM_UP        = 2'd0,
    WM_UP_AUTO   = 2'd1,
    WM_UPDN      = 2'd2,
    WM_UPDN_AUTO = 2'd3
  } wmode_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_e;

  localparam int FLAG_OVF  = 0;
  localparam int FLAG_A    = 1;
  localparam int FLAG_B    = 2;
  localparam int FLAG_TOP  = 3;
  localparam int NUM_FLAGS = 4;
  localparam int NUM_OUTS  = 2;

  // New pin level after applying one action code
  function automatic logic apply_act(input logic cur, input act_e a);
    case (a)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_TGL: return ~cur;
      default: return cur;
    endcase
  endfunction

  // Highest-priority active source with a non-none code decides
  function automatic act_e pick_act(input logic sw, input logic ext,
                                    input logic top, input logic cmp,
                                    input act_e a_sw, input act_e a_ext,
                                    input act_e a_top, input act_e a_cmp);
    if (sw && a_sw != ACT_NONE)        return a_sw;
    else if (ext && a_ext != ACT_NONE) return a_ext;
    else if (top && a_top != ACT_NONE) return a_top;
    else if (cmp && a_cmp != ACT_NONE) return a_cmp;
    else                               return ACT_NONE;
  endfunction

endpackage

// File: rtl/wgt_edge_detect.sv
module wgt_edge_detect
  import wgt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_i,
  input  logic [1:0] edge_sel_i,
  output logic       evt_o
);

  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= ext_i;
  end

  assign rise = ext_i & ~prev_q;
  assign fall = ~ext_i & prev_q;

  always_comb begin
    case (edge_e'(edge_sel_i))
      EDGE_RISE: evt_o = rise;
      EDGE_FALL: evt_o = fall;
      EDGE_BOTH: evt_o = rise | fall;
      default:   evt_o = 1'b0;
    endcase
  end

  AST_EDGE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel_i == 2'(EDGE_NONE)) |-> !evt_o); // R6

endmodule

// File: rtl/wgt_counter.sv
module wgt_counter
  import wgt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             cmd_start_i,
  input  logic             cmd_stop_i,
  input  logic             trig_i,
  input  logic [1:0]       mode_i,
  input  logic             stop_on_top_i,
  input  logic             halt_on_top_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic [CNT_W-1:0] cmp_a_i,
  input  logic [CNT_W-1:0] cmp_b_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_a_o,
  output logic             hit_b_o,
  output logic             hit_top_o,
  output logic             ovf_o
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             up_q, up_d;
  logic             clk_en_q, halted_q, pend_q;
  logic             adv, trig_go, ovf_ev, top_hit;
  logic             updn, auto_mode;
  logic [CNT_W-1:0] turn_pt;

  assign updn      = mode_i[1];
  assign auto_mode = mode_i[0];
  assign adv       = tick_i & clk_en_q & ~halted_q;
  assign trig_go   = adv & (trig_i | pend_q);
  assign top_hit   = adv & (cnt_q == top_i);
  assign turn_pt   = auto_mode ? top_i : CNT_MAX;

  always_comb begin
    cnt_d  = cnt_q;
    up_d   = up_q;
    ovf_ev = 1'b0;
    if (trig_go) begin
      cnt_d = CNT_ZERO;
      up_d  = 1'b1;
    end else if (adv) begin
      if (!updn) begin
        if (auto_mode && cnt_q == top_i) begin
          cnt_d = CNT_ZERO;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          ovf_ev = (cnt_q == CNT_MAX);
        end
      end else if (up_q) begin
        if (cnt_q == turn_pt) begin
          up_d  = 1'b0;
          cnt_d = cnt_q - 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == CNT_ZERO) begin
          up_d  = 1'b1;
          cnt_d = cnt_q + 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      up_q     <= 1'b1;
      clk_en_q <= 1'b0;
      halted_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
      if (cmd_stop_i || (top_hit && halt_on_top_i)) clk_en_q <= 1'b0;
      else if (cmd_start_i)                         clk_en_q <= 1'b1;
      if (trig_i)                             halted_q <= 1'b0;
      else if (top_hit && stop_on_top_i)      halted_q <= 1'b1;
      if (trig_go)     pend_q <= 1'b0;
      else if (trig_i) pend_q <= 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign hit_a_o   = adv & (cnt_q == cmp_a_i);
  assign hit_b_o   = adv & (cnt_q == cmp_b_i);
  assign hit_top_o = top_hit;
  assign ovf_o     = ovf_ev;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(cnt_q)); // R12
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop_i |=> !clk_en_q); // R2
  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> (cnt_q == CNT_ZERO)); // R3
  AST_AUTO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && mode_i == 2'(WM_UP_AUTO) && cnt_q == top_i) |=> (cnt_q == CNT_ZERO)); // R4
  AST_TRIG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    trig_go |=> (cnt_q == CNT_ZERO)); // R6
  AST_FREEZE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (top_hit && stop_on_top_i && !trig_i) |=> halted_q); // R7
  AST_UPDN_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    updn |-> !ovf_ev); // R5

endmodule

// File: rtl/wgt_wave_out.sv
module wgt_wave_out
  import wgt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_i,
  input  logic       ext_i,
  input  logic       top_i,
  input  logic       cmp_i,
  input  logic [1:0] act_sw_i,
  input  logic [1:0] act_ext_i,
  input  logic [1:0] act_top_i,
  input  logic [1:0] act_cmp_i,
  output logic       wave_o
);

  logic wave_q;
  act_e code;

  assign code = pick_act(sw_i, ext_i, top_i, cmp_i,
                         act_e'(act_sw_i), act_e'(act_ext_i),
                         act_e'(act_top_i), act_e'(act_cmp_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= 1'b0;
    else        wave_q <= apply_act(wave_q, code);
  end

  assign wave_o = wave_q;

  AST_WAVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (code == ACT_NONE) |=> $stable(wave_q)); // R8
  AST_SW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_i && act_sw_i == 2'(ACT_CLR)) |=> !wave_q); // R9

endmodule

// File: rtl/wgt_status.sv
module wgt_status #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] ev_i,
  input  logic          rd_i,
  input  logic [NF-1:0] mask_set_i,
  input  logic [NF-1:0] mask_clr_i,
  output logic [NF-1:0] flags_o,
  output logic [NF-1:0] mask_o,
  output logic          irq_o
);

  logic [NF-1:0] flags_q, mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      mask_q  <= '0;
    end else begin
      flags_q <= (rd_i ? '0 : flags_q) | ev_i;
      mask_q  <= (mask_q | mask_set_i) & ~mask_clr_i;
    end
  end

  assign flags_o = flags_q;
  assign mask_o  = mask_q;
  assign irq_o   = |(flags_q & mask_q);

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_i) |=> ((flags_q & $past(ev_i)) == $past(ev_i))); // R10
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (|mask_clr_i) |=> ((mask_q & $past(mask_clr_i)) == '0)); // R11

endmodule

// File: rtl/wgt_channel.sv
module wgt_channel
  import wgt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_tick,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic             cmd_kick,
  input  logic [1:0]       wave_mode,
  input  logic             stop_on_top,
  input  logic             halt_on_top,
  input  logic             ext_in,
  input  logic [1:0]       ext_edge,
  input  logic             ext_trig_en,
  input  logic [CNT_W-1:0] cmp_a_val,
  input  logic [CNT_W-1:0] cmp_b_val,
  input  logic [CNT_W-1:0] top_val,
  input  logic [1:0]       act_a_cmp,
  input  logic [1:0]       act_a_top,
  input  logic [1:0]       act_a_ext,
  input  logic [1:0]       act_a_sw,
  input  logic [1:0]       act_b_cmp,
  input  logic [1:0]       act_b_top,
  input  logic [1:0]       act_b_ext,
  input  logic [1:0]       act_b_sw,
  input  logic             stat_rd,
  input  logic [3:0]       irq_set,
  input  logic [3:0]       irq_clr,
  output logic [CNT_W-1:0] cnt_value,
  output logic             wave_a,
  output logic             wave_b,
  output logic [3:0]       stat_flags,
  output logic [3:0]       irq_mask,
  output logic             irq
);

  logic                 ext_evt, trig_any;
  logic                 hit_a, hit_b, hit_top, ovf_ev;
  logic [NUM_FLAGS-1:0] events;
  logic [NUM_OUTS-1:0]  cmp_hit, wave_v;
  logic [1:0]           act_cmp [NUM_OUTS];
  logic [1:0]           act_top [NUM_OUTS];
  logic [1:0]           act_ext [NUM_OUTS];
  logic [1:0]           act_sw  [NUM_OUTS];

  wgt_edge_detect u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_i      (ext_in),
    .edge_sel_i (ext_edge),
    .evt_o      (ext_evt)
  );

  assign trig_any = cmd_kick | (ext_evt & ext_trig_en);

  wgt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (cnt_tick),
    .cmd_start_i   (cmd_start),
    .cmd_stop_i    (cmd_stop),
    .trig_i        (trig_any),
    .mode_i        (wave_mode),
    .stop_on_top_i (stop_on_top),
    .halt_on_top_i (halt_on_top),
    .top_i         (top_val),
    .cmp_a_i       (cmp_a_val),
    .cmp_b_i       (cmp_b_val),
    .cnt_o         (cnt_value),
    .hit_a_o       (hit_a),
    .hit_b_o       (hit_b),
    .hit_top_o     (hit_top),
    .ovf_o         (ovf_ev)
  );

  assign cmp_hit = {hit_b, hit_a};
  assign act_cmp[0] = act_a_cmp;  assign act_cmp[1] = act_b_cmp;
  assign act_top[0] = act_a_top;  assign act_top[1] = act_b_top;
  assign act_ext[0] = act_a_ext;  assign act_ext[1] = act_b_ext;
  assign act_sw[0]  = act_a_sw;   assign act_sw[1]  = act_b_sw;

  for (genvar g = 0; g < NUM_OUTS; g++) begin : g_out
    wgt_wave_out u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_i      (cmd_kick),
      .ext_i     (ext_evt),
      .top_i     (hit_top),
      .cmp_i     (cmp_hit[g]),
      .act_sw_i  (act_sw[g]),
      .act_ext_i (act_ext[g]),
      .act_top_i (act_top[g]),
      .act_cmp_i (act_cmp[g]),
      .wave_o    (wave_v[g])
    );
  end

  assign wave_a = wave_v[0];
  assign wave_b = wave_v[1];

  always_comb begin
    events           = '0;
    events[FLAG_OVF] = ovf_ev;
    events[FLAG_A]   = hit_a;
    events[FLAG_B]   = hit_b;
    events[FLAG_TOP] = hit_top;
  end

  wgt_status #(.NF(NUM_FLAGS)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_i       (events),
    .rd_i       (stat_rd),
    .mask_set_i (irq_set),
    .mask_clr_i (irq_clr),
    .flags_o    (stat_flags),
    .mask_o     (irq_mask),
    .irq_o      (irq)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (cnt_value == '0 && !wave_a && !wave_b)); // R1

endmodule

// File: tb/wgt_channel_bench.sv
`timescale 1ns/1ps
module wgt_channel_bench;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cnt_tick, cmd_start, cmd_stop, cmd_kick;
  logic [1:0]   wave_mode;
  logic         stop_on_top, halt_on_top;
  logic         ext_in, ext_trig_en;
  logic [1:0]   ext_edge;
  logic [W-1:0] cmp_a_val, cmp_b_val, top_val;
  logic [1:0]   act_a_cmp, act_a_top, act_a_ext, act_a_sw;
  logic [1:0]   act_b_cmp, act_b_top, act_b_ext, act_b_sw;
  logic         stat_rd;
  logic [3:0]   irq_set, irq_clr;
  logic [W-1:0] cnt_value;
  logic         wave_a, wave_b, irq;
  logic [3:0]   stat_flags, irq_mask;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  wgt_channel #(.CNT_W(W)) u_wgt_channel (.*);

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    cmd_start = 1'b1; step(1); cmd_start = 1'b0;
  endtask

  task automatic pulse_kick();
    cmd_kick = 1'b1; step(1); cmd_kick = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cnt_tick = 1'b1; cmd_start = 1'b0; cmd_stop = 1'b0; cmd_kick = 1'b0;
    wave_mode = 2'd0; stop_on_top = 1'b0; halt_on_top = 1'b0;
    ext_in = 1'b0; ext_edge = 2'd0; ext_trig_en = 1'b0;
    cmp_a_val = 8'd200; cmp_b_val = 8'd201; top_val = 8'd250;
    act_a_cmp = 2'd0; act_a_top = 2'd0; act_a_ext = 2'd0; act_a_sw = 2'd0;
    act_b_cmp = 2'd0; act_b_top = 2'd0; act_b_ext = 2'd0; act_b_sw = 2'd0;
    stat_rd = 1'b0; irq_set = 4'd0; irq_clr = 4'd0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 count", cnt_value, 0);
    check("R1 wave_a", wave_a, 0);
    check("R1 wave_b", wave_b, 0);
    check("R1 flags", stat_flags, 0);
    check("R1 mask", irq_mask, 0);
    step(5);
    check("R1 clock off holds count", cnt_value, 0);
  endtask

  task automatic t_clock_cmds();
    do_reset();
    pulse_start();
    check("R2 count at start", cnt_value, 0);
    step(3);
    check("R2 counting", cnt_value, 3);
    cnt_tick = 1'b0;
    step(4);
    check("R12 no tick holds", cnt_value, 3);
    cnt_tick = 1'b1;
    cmd_start = 1'b1; cmd_stop = 1'b1; step(1);
    cmd_start = 1'b0; cmd_stop = 1'b0;
    check("R2 last tick", cnt_value, 4);
    step(4);
    check("R2 stop wins", cnt_value, 4);
  endtask

  task automatic t_overflow();
    do_reset();
    pulse_start();
    step(255);
    check("R3 at max", cnt_value, 255);
    check("R3 no ovf yet", stat_flags[0], 0);
    step(1);
    check("R3 wrap", cnt_value, 0);
    check("R10 all flags", stat_flags, 15);
    stat_rd = 1'b1; step(1); stat_rd = 1'b0;
    check("R10 read clears", stat_flags, 0);
    cmp_a_val = 8'd3;
    step(2);
    check("R10 count before race", cnt_value, 3);
    stat_rd = 1'b1; step(1); stat_rd = 1'b0;
    check("R10 event beats read", stat_flags, 2);
  endtask

  task automatic t_auto();
    do_reset();
    wave_mode = 2'd1; top_val = 8'd4;
    pulse_start();
    step(4);
    check("R4 at top", cnt_value, 4);
    step(1);
    check("R4 restart", cnt_value, 0);
    check("R10 top flag only", stat_flags, 8);
  endtask

  task automatic t_updown();
    int exp_seq[8] = '{1, 2, 3, 2, 1, 0, 1, 2};
    do_reset();
    wave_mode = 2'd3; top_val = 8'd3;
    pulse_start();
    foreach (exp_seq[i]) begin
      step(1);
      check("R5 mode3 sequence", cnt_value, exp_seq[i]);
    end
    do_reset();
    wave_mode = 2'd2;
    pulse_start();
    step(255);
    check("R5 mode2 at max", cnt_value, 255);
    step(1);
    check("R5 mode2 turn", cnt_value, 254);
    check("R5 no ovf", stat_flags[0], 0);
  endtask

  task automatic t_trigger();
    do_reset();
    pulse_start();
    step(10);
    check("R6 before kick", cnt_value, 10);
    pulse_kick();
    check("R6 kick zero", cnt_value, 0);
    step(2);
    cnt_tick = 1'b0;
    pulse_kick();
    step(2);
    check("R6 held without tick", cnt_value, 2);
    cnt_tick = 1'b1;
    step(1);
    check("R6 pending applied", cnt_value, 0);
    ext_trig_en = 1'b1; ext_edge = 2'd1;
    step(5);
    ext_in = 1'b1; step(1);
    check("R6 rising trig", cnt_value, 0);
    step(3);
    ext_in = 1'b0; step(1);
    check("R6 falling ignored in rise mode", cnt_value, 4);
    ext_edge = 2'd2;
    ext_in = 1'b1; step(1);
    check("R6 rising ignored in fall mode", cnt_value, 5);
    ext_in = 1'b0; step(1);
    check("R6 falling trig", cnt_value, 0);
    ext_edge = 2'd3; ext_trig_en = 1'b0;
    step(2);
    ext_in = 1'b1; step(1);
    check("R6 trigger disabled", cnt_value, 3);
  endtask

  task automatic t_stop_halt();
    do_reset();
    wave_mode = 2'd1; top_val = 8'd4; stop_on_top = 1'b1;
    pulse_start();
    step(5);
    step(3);
    check("R7 frozen", cnt_value, 0);
    pulse_kick();
    step(2);
    check("R7 trigger restarts", cnt_value, 1);
    do_reset();
    wave_mode = 2'd1; top_val = 8'd4; halt_on_top = 1'b1;
    pulse_start();
    step(5);
    pulse_kick();
    step(3);
    check("R7 halted ignores trigger", cnt_value, 0);
    pulse_start();
    step(2);
    check("R7 start resumes", cnt_value, 1);
  endtask

  task automatic t_actions();
    do_reset();
    wave_mode = 2'd1; top_val = 8'd6;
    cmp_a_val = 8'd3; act_a_cmp = 2'd1; act_a_top = 2'd2;
    cmp_b_val = 8'd2; act_b_cmp = 2'd3;
    pulse_start();
    step(3);
    check("R8 a before match", wave_a, 0);
    check("R8 b toggled", wave_b, 1);
    step(1);
    check("R8 a set", wave_a, 1);
    step(3);
    check("R8 a cleared at top", wave_a, 0);
    ext_edge = 2'd1; ext_in = 1'b1; step(1); ext_in = 1'b0;
    check("R8 none code ignored", wave_b, 1);
    step(2);
    check("R8 b toggled back", wave_b, 0);
  endtask

  task automatic t_priority();
    do_reset();
    wave_mode = 2'd1; top_val = 8'd4;
    act_a_top = 2'd1; act_a_sw = 2'd2;
    pulse_start();
    step(4);
    pulse_kick();
    check("R9 sw beats top", wave_a, 0);
    step(4);
    check("R9 count", cnt_value, 4);
    step(1);
    check("R9 top alone", wave_a, 1);
    act_a_sw = 2'd0; act_a_top = 2'd2;
    step(4);
    pulse_kick();
    check("R9 none code skipped", wave_a, 0);
  endtask

  task automatic t_irq();
    do_reset();
    irq_set = 4'b1000; step(1); irq_set = 4'd0;
    check("R11 mask set", irq_mask, 8);
    check("R11 no flag no irq", irq, 0);
    wave_mode = 2'd1; top_val = 8'd2;
    pulse_start();
    step(3);
    check("R11 irq on top flag", irq, 1);
    irq_set = 4'b1000; irq_clr = 4'b1000; step(1);
    irq_set = 4'd0; irq_clr = 4'd0;
    check("R11 clear wins", irq_mask, 0);
    check("R11 irq masked", irq, 0);
  endtask

  initial begin
    t_reset();
    t_clock_cmds();
    t_overflow();
    t_auto();
    t_updown();
    t_trigger();
    t_stop_halt();
    t_actions();
    t_priority();
    t_irq();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule